// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers characters from an asynchronous serial line. A separate rate generator supplies a one-clock tick at 16 or 8 times the bit rate. On each tick the receiver samples a synchronised copy of the line. It finds the falling edge of a start bit, then decides every bit from a three-sample majority vote taken at the middle of the bit. The frame is one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit.

Each finished character goes into a holding register. Five status flags describe it: data available, overrun, framing error, parity error and noise. Software or a DMA engine empties the holding register by pulsing a read strobe, and that strobe also clears every flag. An interrupt request stays high for as long as the holding register or an overrun is waiting to be serviced.

Top module: `serial_rx_unit`

## Requirements
- R1: After a synchronous active-low reset, `rx_data` is 0x00 and `st_avail`, `st_overrun`, `st_framing`, `st_parity`, `st_noise` and `irq` are all 0.
- R2: A frame is a 0 start bit, eight data bits with the least significant bit first, a parity bit only when `par_en`=1, and a stop bit. When the frame completes, the data byte appears on `rx_data` and `st_avail` goes to 1.
- R3: With `os_x8`=0 every bit lasts 16 ticks of `os_tick`. With `os_x8`=1 every bit lasts 8 ticks. The rate and parity settings are captured when the start edge is detected.
- R4: Each bit value is the majority of the samples at indices 7, 8 and 9 of the bit (indices 3, 4 and 5 at 8x), where index 0 is the tick that detects the start edge. A single wrong sample among the three does not change the bit.
- R5: If the start bit votes 1, the receiver returns to idle. No character is produced, and a following valid frame is still received.
- R6: With `par_en`=1, even parity (`par_odd`=0) expects the parity bit to equal the XOR of the data bits, and odd parity expects its inverse. A mismatch sets `st_parity`.
- R7: `st_framing` is set with the character when the stop bit votes 0.
- R8: `st_noise` is set with the character when any start-bit sample reads 1 but the start vote is still 0.
- R9: If a character completes while `st_avail`=1 and no read is happening in the same cycle, `st_overrun` goes to 1, and `rx_data` and the other flags keep their values.
- R10: A one-cycle `rd_strobe` clears `st_avail`, `st_overrun`, `st_framing`, `st_parity` and `st_noise` on the next clock.
- R11: `irq` is 1 exactly when `st_avail` or `st_overrun` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | One-cycle oversampling tick |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| os_x8 | input | 1 | 1 = 8x oversampling, 0 = 16x oversampling |
| rd_strobe | input | 1 | Holding-register read pulse |
| rx_data | output | 8 | Received character |
| st_avail | output | 1 | Character waiting to be read |
| st_overrun | output | 1 | A character was lost to unread data |
| st_framing | output | 1 | Stop bit read as 0 |
| st_parity | output | 1 | Parity mismatch |
| st_noise | output | 1 | A 1 was seen inside the start bit |
| irq | output | 1 | Service request |

## Verification
A sample counter that drifts or picks the wrong mid-bit window shows up at the end of the same frame. The assembled byte comes out shifted or has bits flipped, and the parity flag can fire wrongly. A state machine stuck outside idle shows up one frame later: the next frame produces no character, or it produces garbage. Flags that fail to clear on a read, or an overrun that overwrites the held data, are visible on the very next clock after the read, or after the second character arrives.

// File: rtl/serial_rx_pkg.sv
// Shared types for the serial receiver.
// Assumes: one character is handled at a time; the error set is fixed.
package serial_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic framing;
        logic parity;
        logic noise;
    } rx_err_t;

endpackage

// File: rtl/serial_rx_sync.sv
// Synchroniser chain that brings the asynchronous line into the clock domain.
// Assumes: STAGES >= 2; the line idles high, so every stage resets to 1.
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw line through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
// Frame engine: finds the start edge, counts samples within each bit and
// votes over three mid-bit samples. It then assembles the data bits, checks
// parity and the stop bit, and emits a one-cycle done pulse with the results.
// Assumes: tick is a single-cycle pulse; OS_MAX is a power of two >= 8.
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OS_MAX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              os_x8,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output rx_err_t           err
);
    localparam int CNT_W = $clog2(OS_MAX);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_FULL  = CNT_W'(OS_MAX / 2);
    localparam logic [CNT_W-1:0] MID_HALF  = CNT_W'(OS_MAX / 4);
    localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(OS_MAX - 1);
    localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(OS_MAX / 2 - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);

    rx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bit_idx;
    logic [DATA_W-1:0]  shreg;
    logic [1:0]         votes;
    logic               pen_l, podd_l, x8_l, noise_l, perr_l;
    logic [CNT_W-1:0]   mid_c, mid_m1, mid_p1, last_c;
    logic               vote;

    // Select the mid-bit window and the bit length for the captured rate.
    always_comb begin
        mid_c  = x8_l ? MID_HALF  : MID_FULL;
        last_c = x8_l ? LAST_HALF : LAST_FULL;
        mid_m1 = mid_c - 1'b1;
        mid_p1 = mid_c + 1'b1;
        vote   = (votes[1] & votes[0]) | (votes[1] & rx_s) | (votes[0] & rx_s);
    end

    // Sequence through the frame one oversampling tick at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            votes   <= '0;
            pen_l   <= 1'b0;
            podd_l  <= 1'b0;
            x8_l    <= 1'b0;
            noise_l <= 1'b0;
            perr_l  <= 1'b0;
            done    <= 1'b0;
            err     <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == ST_IDLE) begin
                    if (!rx_s) begin
                        state   <= ST_START;
                        cnt     <= CNT_W'(1);
                        pen_l   <= par_en;
                        podd_l  <= par_odd;
                        x8_l    <= os_x8;
                        noise_l <= 1'b0;
                        perr_l  <= 1'b0;
                    end
                end else begin
                    cnt <= (cnt == last_c) ? '0 : cnt + 1'b1;
                    if (cnt == mid_m1) votes[1] <= rx_s;
                    if (cnt == mid_c)  votes[0] <= rx_s;
                    unique case (state)
                        ST_START: begin
                            if (rx_s) noise_l <= 1'b1;
                            if (cnt == mid_p1 && vote) begin
                                state <= ST_IDLE;
                            end else if (cnt == last_c) begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                            end
                        end
                        ST_DATA: begin
                            if (cnt == mid_p1) shreg <= {vote, shreg[DATA_W-1:1]};
                            if (cnt == last_c) begin
                                if (bit_idx == LAST_BIT) state <= pen_l ? ST_PAR : ST_STOP;
                                else                     bit_idx <= bit_idx + 1'b1;
                            end
                        end
                        ST_PAR: begin
                            if (cnt == mid_p1) perr_l <= vote ^ (^shreg) ^ podd_l;
                            if (cnt == last_c) state <= ST_STOP;
                        end
                        ST_STOP: begin
                            if (cnt == mid_p1) begin
                                state       <= ST_IDLE;
                                done        <= 1'b1;
                                err.framing <= ~vote;
                                err.parity  <= pen_l & perr_l;
                                err.noise   <= noise_l;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign data = shreg;

    // R2: the completion pulse lasts exactly one clock
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: at 8x the sample index never passes the shorter bit length
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && x8_l) |-> (cnt <= LAST_HALF));
    // R5: a start bit that votes 1 drops back to idle with no character
    a_r5_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_START && cnt == mid_p1 && vote) |=> (state == ST_IDLE && !done));
endmodule

// File: rtl/serial_rx_status.sv
// Holding register and status flags. It loads a finished character unless
// unread data is still held, in which case it flags an overrun instead.
// A read clears the flags.
// Assumes: done is a one-cycle pulse; a read in the same cycle frees the register.
module serial_rx_status
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data_in,
    input  rx_err_t           err_in,
    input  logic              rd,
    output logic [DATA_W-1:0] data_q,
    output logic              avail,
    output logic              ovr,
    output rx_err_t           err_q,
    output logic              irq
);
    logic blocked;
    assign blocked = avail & ~rd;

    // Apply the read clear first, then load or flag the new character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            avail  <= 1'b0;
            ovr    <= 1'b0;
            err_q  <= '0;
        end else begin
            if (rd) begin
                avail <= 1'b0;
                ovr   <= 1'b0;
                err_q <= '0;
            end
            if (done) begin
                if (blocked) begin
                    ovr <= 1'b1;
                end else begin
                    data_q <= data_in;
                    avail  <= 1'b1;
                    err_q  <= err_in;
                end
            end
        end
    end

    // Request service while a character or an overrun is pending.
    always_comb irq = avail | ovr;

    // R9: an overrun keeps the held character
    a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (done && blocked) |=> (ovr && avail && $stable(data_q)));
    // R2: an accepted character lands in the holding register
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !blocked) |=> (avail && data_q == $past(data_in)));
    // R10: a read with no arrival clears every flag
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> (!avail && !ovr && err_q == '0));
endmodule

// File: rtl/serial_rx_unit.sv
// Top of the serial receiver: synchroniser, frame engine and status register.
// Assumes: os_tick comes from an external rate generator at 16x or 8x baud.
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OS_MAX      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              os_x8,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              st_avail,
    output logic              st_overrun,
    output logic              st_framing,
    output logic              st_parity,
    output logic              st_noise,
    output logic              irq
);
    logic              rx_s;
    logic              fr_done;
    logic [DATA_W-1:0] fr_data;
    rx_err_t           fr_err;
    rx_err_t           st_err;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(rx_line), .d_sync(rx_s)
    );

    serial_rx_frame #(.DATA_W(DATA_W), .OS_MAX(OS_MAX)) u_frame (
        .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .tick(os_tick),
        .par_en(par_en), .par_odd(par_odd), .os_x8(os_x8),
        .done(fr_done), .data(fr_data), .err(fr_err)
    );

    serial_rx_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .done(fr_done), .data_in(fr_data),
        .err_in(fr_err), .rd(rd_strobe), .data_q(rx_data),
        .avail(st_avail), .ovr(st_overrun), .err_q(st_err), .irq(irq)
    );

    assign st_framing = st_err.framing;
    assign st_parity  = st_err.parity;
    assign st_noise   = st_err.noise;
endmodule

// File: tb/serial_rx_unit_bench.sv
module serial_rx_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b1, os_tick = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic os_x8 = 1'b0, rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic st_avail, st_overrun, st_framing, st_parity, st_noise, irq;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    serial_rx_unit u_serial_rx_unit (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .par_en(par_en), .par_odd(par_odd), .os_x8(os_x8), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .st_avail(st_avail), .st_overrun(st_overrun),
        .st_framing(st_framing), .st_parity(st_parity), .st_noise(st_noise), .irq(irq)
    );

    // {data, pen, podd, x8, flip parity, bad stop, exp parity err, exp framing err}
    localparam logic [14:0] VECS [7] = '{
        {8'hA5, 7'b0000000},
        {8'h3C, 7'b1000000},
        {8'h3C, 7'b1110000},
        {8'h81, 7'b1011010},
        {8'hF0, 7'b1101010},
        {8'h00, 7'b0010101},
        {8'h7E, 7'b1000101}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick_once(input logic v);
        rx_line = v;
        repeat (3) @(negedge clk);
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                              input logic x8, input logic pflip, input logic stopbad,
                              input int noise_idx, input logic glitch);
        int n   = x8 ? 8 : 16;
        int mid = x8 ? 4 : 8;
        logic p = (podd ? ~^d : ^d) ^ pflip;
        par_en = pen; par_odd = podd; os_x8 = x8;
        for (int i = 0; i < n; i++) tick_once(i == noise_idx);
        for (int k = 0; k < 8; k++)
            for (int i = 0; i < n; i++)
                tick_once((glitch && k == 0 && i == mid) ? ~d[k] : d[k]);
        if (pen) for (int i = 0; i < n; i++) tick_once(p);
        if (stopbad) begin
            for (int i = 0; i < mid + 2; i++) tick_once(1'b0);
            for (int i = mid + 2; i < n; i++) tick_once(1'b1);
        end else begin
            for (int i = 0; i < n; i++) tick_once(1'b1);
        end
        repeat (2) tick_once(1'b1);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 data", rx_data, 0);
        check("R1 flags", {st_avail, st_overrun, st_framing, st_parity, st_noise, irq}, 0);

        // Table walk: R2 R3 R6 R7 R10 R11
        for (int v = 0; v < 7; v++) begin
            logic [14:0] e = VECS[v];
            send_frame(e[14:7], e[6], e[5], e[4], e[3], e[2], -1, 1'b0);
            check("R2/R3 data", rx_data, e[14:7]);
            check("R2 avail", st_avail, 1);
            check("R6 parity", st_parity, e[1]);
            check("R7 framing", st_framing, e[0]);
            check("R8 noise clean", st_noise, 0);
            check("R11 irq", irq, 1);
            do_read();
            check("R10 cleared", {st_avail, st_framing, st_parity, irq}, 0);
        end

        // R4: a single wrong mid sample is outvoted, both rates
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b1);
        check("R4 vote 16x", rx_data, 8'h5A);
        do_read();
        send_frame(8'hC4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, -1, 1'b1);
        check("R4 vote 8x", rx_data, 8'hC4);
        check("R4 parity ok", st_parity, 0);
        do_read();

        // R5: a short low pulse is a false start
        os_x8 = 1'b0; par_en = 1'b0;
        for (int i = 0; i < 16; i++) tick_once(i >= 3);
        repeat (4) tick_once(1'b1);
        check("R5 no char", st_avail, 0);
        send_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
        check("R5 recovered", rx_data, 8'h96);
        do_read();

        // R8: a 1 inside the start bit away from the vote window
        send_frame(8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2, 1'b0);
        check("R8 noise", st_noise, 1);
        check("R8 data", rx_data, 8'h33);
        do_read();
        check("R10 noise cleared", st_noise, 0);

        // R9: second character while the first is unread
        send_frame(8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, -1, 1'b0);
        send_frame(8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, -1, 1'b0);
        check("R9 data kept", rx_data, 8'h11);
        check("R9 overrun", st_overrun, 1);
        check("R9 framing untouched", st_framing, 0);
        check("R11 irq overrun", irq, 1);
        do_read();
        check("R10 overrun cleared", {st_avail, st_overrun, irq}, 0);

        summary();
    end
endmodule